// File: doc/BRIEF.md
# Flash Line Buffer Controller

This block sits between a 32-bit read port and a flash array that delivers 128-bit lines. It keeps two full lines, each with its own tag, so that repeated reads and reads that walk through a line are answered from the buffer. A buffered read costs no wait cycles. Any read outside the buffer starts an array access. That access takes a programmed number of wait cycles and then writes the returned line into the least recently used buffer. The requested word is passed to the bus in the same cycle as the write.

When speculation is on, every read served from a line that has no resident successor also starts a fetch of the following line. This lets a sequential reader cross line boundaries without stalling while the wait count is small. Four maintenance events each empty both buffers at once: a configuration write, an initialization, a data-latch read and an index-sector read. The array is outside the block. The block drives a line address and a fetch-active flag. It takes the 128-bit line on the cycle its wait count expires.

Top module: `flash_line_cache`

## Requirements
- R1: A read whose line (word address bits above bit 1) matches a valid buffer tag completes in the same cycle, with `rd_ready` high and no wait. The word inside the line is chosen by word-address bits [1:0], where 0 is array bits [31:0] and 3 is array bits [127:96].
- R2: After reset `rd_ready` and `arr_rd` are low. A read that matches neither buffer, with no fetch in progress, holds `rd_ready` low for exactly `wait_states`+1 cycles. It then completes with the word taken straight from `arr_data`.
- R3: Both buffers stay usable at once: after two different lines are loaded, reads to either line complete with no wait.
- R4: A miss replaces the buffer that was read least recently. The other line remains resident.
- R5: A one-cycle pulse on `evt_cfg` invalidates both buffers, so the next read of a previously buffered line misses.
- R6: A one-cycle pulse on `evt_init` invalidates both buffers.
- R7: A one-cycle pulse on `evt_latch` or on `evt_index` invalidates both buffers.
- R8: With `spec_en` low, the next line is never fetched ahead: the first read of line L+1 after line L misses with the full `wait_states`+1 stall.
- R9: With `spec_en` high and `wait_states` at most 3, a line-aligned run of back-to-back sequential reads stalls only on its first word.
- R10: With `spec_en` high and `wait_states` W greater than 3, the same run stalls W-3 cycles on the first word of every line after the first.
- R11: A read that misses both buffers and differs from the line being fetched speculatively abandons that fetch at once and is served after `wait_states`+1 cycles. The abandoned line is not loaded.
- R12: A speculative fetch is dropped when the bus reads the buffer it was going to overwrite. That line stays resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read request, held with a stable address until `rd_ready` |
| rd_word | input | AW-2 | 32-bit word address; bits [1:0] select the word within a line |
| rd_ready | output | 1 | Read completes this cycle |
| rd_data | output | 32 | Read data, valid while `rd_ready` is high |
| wait_states | input | WS_W | Array wait cycles per access |
| spec_en | input | 1 | Enable speculative next-line fetch |
| evt_cfg | input | 1 | Configuration write event, empties both buffers |
| evt_init | input | 1 | Initialization event, empties both buffers |
| evt_latch | input | 1 | Data-latch read event, empties both buffers |
| evt_index | input | 1 | Index-sector read event, empties both buffers |
| arr_rd | output | 1 | Array access in progress |
| arr_line | output | AW-4 | Line address presented to the array |
| arr_data | input | 128 | Line data from the array, sampled when the wait count expires |

## Verification
The assertions assume the bus behaves like a pipelined read port. A stalled request keeps its address and stays asserted until it is served. `wait_states` changes only together with a configuration event. The stall-length and speculation-off checks depend on both assumptions. The bench drives every read through one task that holds `rd_req` and `rd_word` until `rd_ready`. It changes the wait count only through a task that pulses `evt_cfg` in the same cycle. The array model in the bench is a pure function of `arr_line`, so its data is always valid by the time the wait count expires.

// File: rtl/flash_line_cache.sv
module flash_line_cache #(
  parameter int AW   = 16,
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [AW-3:0]   rd_word,
  output logic            rd_ready,
  output logic [31:0]     rd_data,
  input  logic [WS_W-1:0] wait_states,
  input  logic            spec_en,
  input  logic            evt_cfg,
  input  logic            evt_init,
  input  logic            evt_latch,
  input  logic            evt_index,
  output logic            arr_rd,
  output logic [AW-5:0]   arr_line,
  input  logic [127:0]    arr_data
);
  localparam int TW = AW - 4;

  typedef enum logic [1:0] {S_IDLE, S_DEMAND, S_SPEC} st_t;

  st_t             st_q;
  logic [1:0]      vld_q;
  logic [TW-1:0]   tag_q  [2];
  logic [127:0]    line_q [2];
  logic            lru_q, way_q;
  logic [TW-1:0]   fa_q;
  logic [WS_W-1:0] cnt_q;

  wire          flush    = evt_cfg | evt_init | evt_latch | evt_index;
  wire [TW-1:0] req_line = rd_word[AW-3:2];
  wire [1:0]    wsel     = rd_word[1:0];
  wire          hit0     = vld_q[0] && (tag_q[0] == req_line);
  wire          hit1     = vld_q[1] && (tag_q[1] == req_line);
  wire          hit      = hit0 | hit1;
  wire          hit_way  = hit1;
  wire          busy     = (st_q != S_IDLE);

  wire fill_due = busy && (cnt_q == '0) && !flush;
  wire fwd      = fill_due && rd_req && (req_line == fa_q);
  wire hit_ok   = rd_req && hit && (st_q != S_DEMAND) && !flush;

  assign rd_ready = hit_ok | fwd;

  wire          acc_way  = fwd ? way_q : hit_way;
  wire [TW-1:0] nxt_line = req_line + 1'b1;
  wire          nxt_res  = vld_q[~acc_way] && (tag_q[~acc_way] == nxt_line);

  wire cancel   = (st_q == S_SPEC) && hit_ok && (hit_way == way_q);
  wire fill     = fill_due && !cancel;
  wire trig     = spec_en && rd_ready && !nxt_res && ((st_q == S_IDLE) || fwd);
  wire miss_new = rd_req && !hit && !flush &&
                  ((st_q == S_IDLE) || ((st_q == S_SPEC) && (req_line != fa_q)));

  logic lru_d;
  always_comb begin
    lru_d = lru_q;
    if (rd_ready)  lru_d = ~acc_way;
    else if (fill) lru_d = way_q;
  end

  wire [127:0] sel_line = fwd ? arr_data : line_q[hit_way];
  assign rd_data  = sel_line[{wsel, 5'b0} +: 32];
  assign arr_rd   = busy;
  assign arr_line = fa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      vld_q     <= '0;
      tag_q[0]  <= '0;
      tag_q[1]  <= '0;
      line_q[0] <= '0;
      line_q[1] <= '0;
      lru_q     <= 1'b0;
      way_q     <= 1'b0;
      fa_q      <= '0;
      cnt_q     <= '0;
    end else if (flush) begin
      vld_q <= '0;
      st_q  <= S_IDLE;
    end else begin
      if (fill) begin
        line_q[way_q] <= arr_data;
        tag_q[way_q]  <= fa_q;
        vld_q[way_q]  <= 1'b1;
      end
      lru_q <= lru_d;
      if (miss_new) begin
        st_q  <= S_DEMAND;
        fa_q  <= req_line;
        cnt_q <= wait_states;
        way_q <= lru_d;
      end else if (trig) begin
        st_q  <= S_SPEC;
        fa_q  <= nxt_line;
        cnt_q <= wait_states;
        way_q <= ~acc_way;
      end else if (fill || cancel) begin
        st_q <= S_IDLE;
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_line_cache_chk.sv
module flash_line_cache_chk #(
  parameter int AW   = 16,
  parameter int WS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic [AW-3:0]   rd_word,
  input logic            rd_ready,
  input logic [WS_W-1:0] wait_states,
  input logic            spec_en,
  input logic            evt_cfg,
  input logic            evt_init,
  input logic            evt_latch,
  input logic            evt_index,
  input logic            arr_rd,
  input logic [1:0]      vld,
  input logic [AW-5:0]   tag_a,
  input logic [AW-5:0]   tag_b
);
  localparam int OFF_LIM = 2 ** WS_W;

  wire flush_any = evt_cfg | evt_init | evt_latch | evt_index;

  logic [WS_W:0]   stall_q;
  logic [WS_W+1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= '0;
      off_q   <= '0;
    end else begin
      if (rd_req && !rd_ready && !flush_any)
        stall_q <= (stall_q == '1) ? stall_q : stall_q + 1'b1;
      else
        stall_q <= '0;
      if (spec_en)
        off_q <= '0;
      else if (off_q != (WS_W+2)'(OFF_LIM))
        off_q <= off_q + 1'b1;
    end
  end

  AST_REPEAT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_ready) && !$past(flush_any) && rd_req && $stable(rd_word) && !flush_any
      |-> rd_ready); // R1

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready && !flush_any |-> stall_q <= {1'b0, wait_states}); // R2

  AST_UNIQUE_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld[0] && vld[1] && (tag_a == tag_b))); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush_any) && rd_req |-> !rd_ready); // R5

  AST_SPEC_OFF_DEMAND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q == (WS_W+2)'(OFF_LIM)) && arr_rd |-> rd_req); // R8
endmodule

bind flash_line_cache flash_line_cache_chk #(.AW(AW), .WS_W(WS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req      (rd_req),
  .rd_word     (rd_word),
  .rd_ready    (rd_ready),
  .wait_states (wait_states),
  .spec_en     (spec_en),
  .evt_cfg     (evt_cfg),
  .evt_init    (evt_init),
  .evt_latch   (evt_latch),
  .evt_index   (evt_index),
  .arr_rd      (arr_rd),
  .vld         (vld_q),
  .tag_a       (tag_q[0]),
  .tag_b       (tag_q[1])
);

// File: tb/flash_line_cache_test.sv
`timescale 1ns/1ps
module flash_line_cache_test;
  localparam int AW = 16;
  localparam int WS_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_req = 1'b0;
  logic [AW-3:0]   rd_word = '0;
  logic            rd_ready;
  logic [31:0]     rd_data;
  logic [WS_W-1:0] wait_states = '0;
  logic            spec_en = 1'b0;
  logic            evt_cfg = 1'b0, evt_init = 1'b0, evt_latch = 1'b0, evt_index = 1'b0;
  logic            arr_rd;
  logic [AW-5:0]   arr_line;
  logic [127:0]    arr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] word_val(input logic [11:0] ln, input int w);
    return ({20'b0, ln} * 32'h9E3779B1) ^ (w * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [127:0] mk_line(input logic [11:0] ln);
    return {word_val(ln, 3), word_val(ln, 2), word_val(ln, 1), word_val(ln, 0)};
  endfunction

  assign arr_data = mk_line(arr_line);

  flash_line_cache #(.AW(AW), .WS_W(WS_W)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_word(rd_word),
    .rd_ready(rd_ready), .rd_data(rd_data), .wait_states(wait_states),
    .spec_en(spec_en), .evt_cfg(evt_cfg), .evt_init(evt_init),
    .evt_latch(evt_latch), .evt_index(evt_index), .arr_rd(arr_rd),
    .arr_line(arr_line), .arr_data(arr_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input int ln, input int w, input int exp_stall, input string req);
    int stalls = 0;
    @(negedge clk);
    rd_req  = 1'b1;
    rd_word = {ln[11:0], w[1:0]};
    #1;
    while (!rd_ready && stalls < 200) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    check(stalls < 200, {req, " watchdog"}, stalls, 0);
    if (exp_stall >= 0) check(stalls == exp_stall, {req, " stall"}, stalls, exp_stall);
    check(rd_data == word_val(ln[11:0], w), {req, " data"}, rd_data, word_val(ln[11:0], w));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rd_req = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic pulse(input int e);
    @(negedge clk);
    rd_req = 1'b0;
    case (e)
      0: evt_cfg = 1'b1;
      1: evt_init = 1'b1;
      2: evt_latch = 1'b1;
      default: evt_index = 1'b1;
    endcase
    @(negedge clk);
    evt_cfg = 1'b0; evt_init = 1'b0; evt_latch = 1'b0; evt_index = 1'b0;
  endtask

  task automatic set_ws(input int v);
    @(negedge clk);
    rd_req = 1'b0;
    wait_states = v[WS_W-1:0];
    evt_cfg = 1'b1;
    @(negedge clk);
    evt_cfg = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(rd_ready == 1'b0, "R2 reset ready", rd_ready, 0);
    check(arr_rd == 1'b0, "R2 reset arr_rd", arr_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R8: demand misses and hits, speculation off, every wait count 0..7
    for (int ws = 0; ws < 8; ws++) begin
      spec_en = 1'b0;
      set_ws(ws);
      rd(300 + ws * 4, 0, ws + 1, "R2");
      for (int w = 1; w < 4; w++) rd(300 + ws * 4, w, 0, "R1");
      rd(300 + ws * 4, 0, 0, "R1");
      rd(301 + ws * 4, 2, ws + 1, "R8");
    end

    // R3 R4: two resident lines and LRU replacement
    set_ws(2);
    rd(500, 0, 3, "R2");
    rd(600, 1, 3, "R2");
    rd(500, 2, 0, "R3");
    rd(600, 3, 0, "R3");
    rd(500, 0, 0, "R3");
    rd(700, 0, 3, "R4");
    rd(500, 1, 0, "R4");
    rd(600, 0, 3, "R4");

    // R5 R6 R7: each maintenance event empties the buffers
    set_ws(1);
    for (int e = 0; e < 4; e++) begin
      rd(800 + e, 0, -1, "R5");
      rd(800 + e, 1, 0, "R1");
      pulse(e);
      rd(800 + e, 1, 2, e == 0 ? "R5" : (e == 1 ? "R6" : "R7"));
    end

    // R9 R10: sequential streams with speculation on
    for (int ws = 0; ws < 8; ws++) begin
      spec_en = 1'b1;
      set_ws(ws);
      for (int l = 0; l < 4; l++)
        for (int w = 0; w < 4; w++)
          rd(100 + ws * 8 + l, w,
             (l == 0 && w == 0) ? ws + 1 : ((w == 0 && ws > 3) ? ws - 3 : 0),
             ws <= 3 ? "R9" : "R10");
    end

    // R11: demand miss aborts a speculative fetch
    spec_en = 1'b1;
    set_ws(6);
    rd(10, 0, 7, "R2");
    rd(40, 0, 7, "R11");
    rd(11, 0, 7, "R11");

    // R12: reading the victim line cancels speculation
    spec_en = 1'b0;
    set_ws(6);
    rd(50, 0, 7, "R2");
    rd(60, 0, 7, "R2");
    idle(1);
    spec_en = 1'b1;
    rd(50, 1, 0, "R1");
    rd(60, 2, 0, "R12");
    idle(10);
    rd(60, 3, 0, "R12");
    rd(51, 0, 7, "R12");

    idle(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule